// File: doc/BRIEF.md
# Dual-Mode Parallel Pixel Port Timing Generator

This block drives the sensor side of a parallel pixel interface: an 8-bit pixel bus, a row qualifier and a frame qualifier. Every output changes on the rising edge of the pixel clock. Each row holds `COLS` pixel positions, numbered 0 to `COLS`-1 (128 by default). Rows are separated by a horizontal blanking gap. The number of rows, the blanking length and the integration delay are parameters, and each must be at least 1. Pixel values come from a counter pattern, so a receiver can check them.

There are two modes, selected by `snap_mode`. In free-running video mode (`snap_mode`=0) the generator drives the frame line and produces frames back to back. In snapshot mode (`snap_mode`=1) the frame line becomes an input: `frame_oe` drops and `frame_out` is held low. A single frame then starts only when `frame_in` is held high on two consecutive clock edges while the generator is idle. The two wires `frame_in` and `frame_out`, together with the enable `frame_oe`, let surrounding logic build one bidirectional pin.

The controller has five states:
- IDLE waits.
- INTEGRATE counts the integration delay.
- ROW_ACTIVE drives pixels.
- HBLANK drives the gap between rows.
- FRAME_END lasts one cycle after the last pixel.

The transitions are:
- IDLE to INTEGRATE, at once in video mode, or on a qualified trigger in snapshot mode.
- INTEGRATE to ROW_ACTIVE when the delay ends.
- ROW_ACTIVE to HBLANK after the last column of a row that is not the last row.
- ROW_ACTIVE to FRAME_END after the last column of the last row.
- HBLANK to ROW_ACTIVE when the gap ends.
- FRAME_END to IDLE in snapshot mode, or to INTEGRATE in video mode.

Top module: `pixport_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `row_valid`, `pix` and `frame_out` are 0, and `frame_oe` equals the inverse of `snap_mode`.
- R2: A row is `COLS` consecutive cycles with `row_valid` high. In the cycle for column c of row r (row 0 first), `pix` = (c + r) mod 256.
- R3: Whenever `row_valid` is low, `pix` is 0.
- R4: Between two rows of the same frame, `row_valid` is low for exactly `HBLANK_LEN` cycles.
- R5: In video mode `frame_oe` is 1. `frame_out` is high from the first pixel of row 0 through the last pixel of the last row, including the gaps between rows, and low at all other times.
- R6: In video mode frames repeat without a trigger. Between the last pixel of one frame and the first pixel of the next, `row_valid` is low for exactly `INTEG_LEN`+1 cycles.
- R7: In snapshot mode `frame_oe` and `frame_out` are 0, and no row is produced while no trigger arrives.
- R8: In snapshot mode, if edge k is the first clock edge at which `frame_in` is sampled high and it is still high at edge k+1 while idle, then `row_valid` first rises after edge k+1+`INTEG_LEN`.
- R9: A `frame_in` pulse seen high at only one clock edge starts no frame.
- R10: A `frame_in` level held high for any length starts exactly one frame. A further frame needs `frame_in` to go low first.
- R11: A trigger that goes high while the generator is integrating or reading out is ignored, even if it stays high into the next idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_mode | input | 1 | 0 = free-running video, 1 = triggered snapshot |
| frame_in | input | 1 | Frame line as a trigger input (snapshot mode only) |
| frame_out | output | 1 | Frame qualifier output (video mode) |
| frame_oe | output | 1 | High when the frame line is driven by this block |
| row_valid | output | 1 | Row qualifier, high while pixels are valid |
| pix | output | PIX_W | Pixel bus, 0 during blanking |

## Verification
The assertions assume that `snap_mode` changes only while reset is held, and that `frame_in` is a clean synchronous level sampled on the pixel clock. The stimulus changes `snap_mode` only between reset pulses. It drives `frame_in` one time unit after a falling clock edge, so every pulse covers a whole number of rising edges. Trigger pulses are placed on purpose during idle, during readout and across the end of a frame, which covers the states where the idle-only acceptance rule matters.

// File: rtl/pixport_pkg.sv
package pixport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INTEG  = 3'd1,
        ST_ROW    = 3'd2,
        ST_HBLANK = 3'd3,
        ST_FEND   = 3'd4
    } pp_state_e;

endpackage

// File: rtl/pixport_trig.sv
module pixport_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_in,
    input  logic idle_i,
    output logic fire_o
);

    logic prev_q;
    logic armed_q;

    // Trigger needs two consecutive high samples, an armed latch, and an idle engine.
    assign fire_o = idle_i && frame_in && prev_q && armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q <= frame_in;
            if (!frame_in)
                armed_q <= 1'b1;
            else if (fire_o || !idle_i)
                armed_q <= 1'b0;
        end
    end

    // R10
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // R9
    two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(frame_in));

endmodule

// File: rtl/pixport_seq.sv
module pixport_seq
    import pixport_pkg::*;
#(
    parameter int COLS       = 128,
    parameter int ROWS       = 4,
    parameter int HBLANK_LEN = 3,
    parameter int INTEG_LEN  = 5,
    parameter int COL_W      = 7,
    parameter int ROW_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_mode,
    input  logic             fire_i,
    output pp_state_e        st_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);

    localparam int WAIT_MAX = (HBLANK_LEN > INTEG_LEN) ? HBLANK_LEN : INTEG_LEN;
    localparam int WAIT_W   = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;
    localparam logic [WAIT_W-1:0] INTEG_LD = WAIT_W'(INTEG_LEN - 1);
    localparam logic [WAIT_W-1:0] HBL_LD   = WAIT_W'(HBLANK_LEN - 1);
    localparam logic [COL_W-1:0]  COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST = ROW_W'(ROWS - 1);

    pp_state_e          st_q, st_nx;
    logic [COL_W-1:0]   col_q;
    logic [ROW_W-1:0]   row_q;
    logic [WAIT_W-1:0]  wait_q;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:   if (!snap_mode || fire_i) st_nx = ST_INTEG;
            ST_INTEG:  if (wait_q == '0) st_nx = ST_ROW;
            ST_ROW: begin
                if (col_q == COL_LAST)
                    st_nx = (row_q == ROW_LAST) ? ST_FEND : ST_HBLANK;
            end
            ST_HBLANK: if (wait_q == '0) st_nx = ST_ROW;
            ST_FEND:   st_nx = snap_mode ? ST_IDLE : ST_INTEG;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            wait_q <= '0;
        end else begin
            col_q <= (st_q == ST_ROW && st_nx == ST_ROW) ? col_q + 1'b1 : '0;

            if (st_q == ST_INTEG)
                row_q <= '0;
            else if (st_q == ST_HBLANK && st_nx == ST_ROW)
                row_q <= row_q + 1'b1;

            if (st_nx != st_q)
                wait_q <= (st_nx == ST_INTEG)  ? INTEG_LD :
                          (st_nx == ST_HBLANK) ? HBL_LD   : '0;
            else if (wait_q != '0)
                wait_q <= wait_q - 1'b1;
        end
    end

    assign st_o  = st_q;
    assign row_o = row_q;
    assign col_o = col_q;

    // R2
    row_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_ROW && $past(st_q) == ST_ROW) |-> $past(col_q) == COL_LAST);

    // R5
    frame_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FEND) |-> row_q == ROW_LAST);

    // R4
    hblank_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ROW && $past(st_q) == ST_HBLANK) |-> $past(wait_q) == '0);

endmodule

// File: rtl/pixport_pattern.sv
module pixport_pattern #(
    parameter int COL_W = 7,
    parameter int ROW_W = 2,
    parameter int PIX_W = 8
) (
    input  logic             valid_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output logic [PIX_W-1:0] pix_o
);

    logic [PIX_W-1:0] sum;

    always_comb begin
        sum   = PIX_W'(col_i) + PIX_W'(row_i);
        pix_o = valid_i ? sum : '0;
    end

endmodule

// File: rtl/pixport_gen.sv
module pixport_gen
    import pixport_pkg::*;
#(
    parameter int COLS       = 128,
    parameter int ROWS       = 4,
    parameter int HBLANK_LEN = 3,
    parameter int INTEG_LEN  = 5,
    parameter int PIX_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_mode,
    input  logic             frame_in,
    output logic             frame_out,
    output logic             frame_oe,
    output logic             row_valid,
    output logic [PIX_W-1:0] pix
);

    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    pp_state_e        st;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             fire;
    logic             idle_snap;

    assign idle_snap = (st == ST_IDLE) && snap_mode;

    pixport_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_in),
        .idle_i   (idle_snap),
        .fire_o   (fire)
    );

    pixport_seq #(
        .COLS       (COLS),
        .ROWS       (ROWS),
        .HBLANK_LEN (HBLANK_LEN),
        .INTEG_LEN  (INTEG_LEN),
        .COL_W      (COL_W),
        .ROW_W      (ROW_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_mode (snap_mode),
        .fire_i    (fire),
        .st_o      (st),
        .row_o     (row),
        .col_o     (col)
    );

    always_comb begin
        row_valid = (st == ST_ROW);
        frame_oe  = !snap_mode;
        frame_out = !snap_mode && (st == ST_ROW || st == ST_HBLANK);
    end

    pixport_pattern #(
        .COL_W (COL_W),
        .ROW_W (ROW_W),
        .PIX_W (PIX_W)
    ) u_pat (
        .valid_i (row_valid),
        .row_i   (row),
        .col_i   (col),
        .pix_o   (pix)
    );

    // R5
    vid_frame_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && !snap_mode) |-> frame_out);

    // R8
    trig_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_mode && $past(st) == ST_IDLE && st == ST_INTEG)
            |-> ($past(frame_in) && $past(frame_in, 2)));

    // R7
    snap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_mode |-> (!frame_out && !frame_oe));

endmodule

// File: tb/sim_pixport_gen.sv
module sim_pixport_gen;

    localparam int CLK_P      = 10;
    localparam int COLS       = 128;
    localparam int ROWS       = 4;
    localparam int HBLANK_LEN = 3;
    localparam int INTEG_LEN  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       snap_mode = 1'b0;
    logic       frame_in = 1'b0;
    logic       frame_out, frame_oe, row_valid;
    logic [7:0] pix;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int    pix_q[$];
    int    gap_q[$];
    string gtag_q[$];

    int low_run = 0;
    int mon_row = 0;
    int rows_done = 0;
    int frame_rise_cyc = 0;
    bit prev_rv = 1'b0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc++;

    pixport_gen #(
        .COLS(COLS), .ROWS(ROWS), .HBLANK_LEN(HBLANK_LEN),
        .INTEG_LEN(INTEG_LEN), .PIX_W(8)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .snap_mode(snap_mode), .frame_in(frame_in),
        .frame_out(frame_out), .frame_oe(frame_oe), .row_valid(row_valid), .pix(pix)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Driver: queue the expected pixels and gaps of one frame.
    task automatic push_frame(input int first_gap, input string first_tag);
        for (int r = 0; r < ROWS; r++) begin
            gap_q.push_back(r == 0 ? first_gap : HBLANK_LEN);
            gtag_q.push_back(r == 0 ? first_tag : "R4");
            for (int c = 0; c < COLS; c++) pix_q.push_back((c + r) % 256);
        end
    endtask

    task automatic pulse(input int len, output int t0);
        @(negedge clk); #1;
        frame_in = 1'b1;
        t0 = cyc;
        repeat (len) @(negedge clk);
        #1 frame_in = 1'b0;
    endtask

    task automatic wait_drain();
        while (pix_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            low_run = 0; mon_row = 0; prev_rv = 1'b0;
        end else begin
            chk(frame_oe == !snap_mode, "R5/R7 frame_oe", frame_oe, !snap_mode);
            if (row_valid) begin
                if (!prev_rv) begin
                    if (mon_row == 0) frame_rise_cyc = cyc;
                    if (gap_q.size() != 0) begin
                        int g;
                        string t;
                        g = gap_q.pop_front();
                        t = gtag_q.pop_front();
                        if (g >= 0) chk(low_run == g, t, low_run, g);
                    end
                end
                if (pix_q.size() == 0)
                    chk(1'b0, "R7/R10/R11 unexpected pixel", pix, -1);
                else begin
                    int e;
                    e = pix_q.pop_front();
                    chk(pix == e, "R2 pixel", pix, e);
                end
                chk(frame_out == !snap_mode, "R5 frame_out in row", frame_out, !snap_mode);
                low_run = 0;
            end else begin
                chk(pix == 0, "R3 blank pixel", pix, 0);
                if (prev_rv) begin
                    mon_row = (mon_row + 1) % ROWS;
                    rows_done++;
                end
                chk(frame_out == (!snap_mode && mon_row != 0), "R5 frame_out outside row",
                    frame_out, (!snap_mode && mon_row != 0));
                low_run++;
            end
            prev_rv = row_valid;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int t0, base;
        // R1 reset state, video mode
        repeat (3) @(negedge clk);
        chk(!row_valid && pix == 0 && !frame_out, "R1 in reset", {row_valid, frame_out}, 0);
        chk(frame_oe == 1'b1, "R1 frame_oe video", frame_oe, 1);
        push_frame(-1, "R6");
        push_frame(INTEG_LEN + 1, "R6");
        push_frame(INTEG_LEN + 1, "R6");
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!row_valid && pix == 0 && !frame_out, "R1 after reset", {row_valid, frame_out}, 0);
        wait_drain();   // R6 three frames back to back, R4 gaps, R5 qualifier

        // Snapshot mode
        #1 rst_n = 1'b0; snap_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk(frame_oe == 1'b0 && !row_valid, "R1 frame_oe snapshot", frame_oe, 0);
        #1 rst_n = 1'b1;
        base = rows_done;
        repeat (30) @(negedge clk);
        chk(rows_done == base, "R7 no trigger no rows", rows_done, base);

        pulse(1, t0);
        repeat (30) @(negedge clk);
        chk(rows_done == base, "R9 single-edge pulse", rows_done, base);

        push_frame(-1, "R8");
        pulse(2, t0);
        wait_drain();
        chk(frame_rise_cyc - t0 == INTEG_LEN + 2, "R8 trigger latency",
            frame_rise_cyc - t0, INTEG_LEN + 2);
        chk(rows_done == base + ROWS, "R8 one frame", rows_done, base + ROWS);

        base = rows_done;
        push_frame(-1, "R10");
        pulse(1500, t0);
        repeat (30) @(negedge clk);
        chk(rows_done == base + ROWS, "R10 long pulse one frame", rows_done, base + ROWS);

        base = rows_done;
        push_frame(-1, "R11");
        pulse(2, t0);
        repeat (60) @(negedge clk);
        pulse(2, t0);
        repeat (40) @(negedge clk);
        pulse(700, t0);
        repeat (30) @(negedge clk);
        chk(rows_done == base + ROWS, "R11 busy triggers ignored", rows_done, base + ROWS);
        chk(pix_q.size() == 0, "R11 scoreboard drained", pix_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule